// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block decides which of four SDRAM chip selects owns a physical address. Each chip select has a base register and a size register. Together they describe one aligned window with a granularity of 16 MiB. A word-addressed register port writes and reads these registers. A combinational lookup port takes a 32-bit address and returns three things: a hit flag, the index of the chip select that owns the address, and a 4-bit attribute code. The attribute code is all ones with a single zero at the bit of the winning chip select.

A window can take part in lookups only when it is enabled and its extension bits (the base address bits above bit 31) are all zero. A window with extension bits set lies outside the reach of a 32-bit master. The block also gives a compacted view of the usable windows: a count, and a packed list of their chip-select indices in ascending order. A DMA-capable neighbour can copy this view straight into its own address windows.

Top module: `dram_cs_decoder`

## Requirements
- R1: While reset is applied and after it, every register reads as zero. No window is usable, `use_cnt` and `use_vld` are zero, and every lookup misses with `lk_attr` equal to 4'hF.
- R2: `reg_addr` is a word index. Index 2n selects the base register of chip select n and index 2n+1 selects its size register. A write with `reg_wr_en` high takes effect at the next rising clock edge. `reg_rdata` shows the addressed register combinationally. Without a write, the register state does not change.
- R3: Size register: bit 0 is the enable, bits 4:2 are a 3-bit chip-select tag, and bits 31:24 hold the window size minus one in 16 MiB units. Base register: bits 31:24 hold the base in 16 MiB units, and bits 3:0 hold the address extension bits. All other bits are not stored and read as zero.
- R4: A window covers the addresses from base up to, but not including, base + (size register with bits 23:0 forced to ones) + 1. A window may end exactly at 2^32.
- R5: A window is usable only when its enable bit is 1 and its four extension bits are 0. A window that is not usable never produces a hit.
- R6: When usable windows overlap, the lowest-numbered chip select wins.
- R7: On a hit, `lk_hit` is 1, `lk_cs` is the winning chip select i, and `lk_attr` is 4'hF with bit i cleared.
- R8: On a miss, `lk_hit` is 0, `lk_cs` is 0 and `lk_attr` is 4'hF.
- R9: `use_cnt` is the number of usable windows. Slot k, which is `use_idx[2k+1:2k]`, holds the k-th usable chip select in ascending order, and `use_vld[k]` is 1 for that slot. Unfilled slots hold index 0 with valid 0.
- R10: The lookup outputs and the compacted list follow `lk_addr` and the registers with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (2n base, 2n+1 size) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Address falls in a usable window |
| lk_cs | output | 2 | Winning chip-select index |
| lk_attr | output | 4 | Active-low one-hot attribute of the winner |
| use_cnt | output | 3 | Number of usable windows |
| use_idx | output | 8 | Four packed 2-bit chip-select slots |
| use_vld | output | 4 | Valid bit per slot |

## Verification
The bench builds the block with its default of four chip selects and 16 MiB granularity, so the whole register map and every attribute pattern can be reached. With four windows the bench can place a window that ends exactly at 2^32 and another that sits at address zero. It can also hold one window disabled while another stays enabled with extension bits set, so the two exclusion paths are tested apart. Overlapping windows and partly filled compacted lists fit in the same short run.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_W     = 24;               // 16 MiB granularity
  localparam int HI_W       = ADDR_W - GRAN_W;  // stored upper bits
  localparam int EXT_W      = 4;                // address bits above 32
  localparam int TAG_W      = 3;
  localparam int EN_BIT     = 0;
  localparam int TAG_LSB    = 2;

  typedef struct packed {
    logic [HI_W-1:0]  base_hi;
    logic [EXT_W-1:0] base_ext;
    logic [HI_W-1:0]  size_m1;
    logic [TAG_W-1:0] tag;
    logic             en;
  } win_cfg_t;
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dcs_regfile.sv
module dcs_regfile
  import dcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int WA_W  = CS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output win_cfg_t          cfg_o [NUM_CS]
);
  win_cfg_t        cfg_q [NUM_CS];
  win_cfg_t        cfg_d [NUM_CS];
  logic [CS_W-1:0] sel;
  logic            is_size;
  logic            unused_wbits;

  assign sel          = reg_addr[WA_W-1:1];
  assign is_size      = reg_addr[0];
  assign unused_wbits = ^wdata[GRAN_W-1:TAG_LSB+TAG_W];

  // next-state
  always_comb begin
    for (int i = 0; i < NUM_CS; i++) cfg_d[i] = cfg_q[i];
    if (wr_en) begin
      if (is_size) begin
        cfg_d[sel].size_m1 = wdata[ADDR_W-1 -: HI_W];
        cfg_d[sel].tag     = wdata[TAG_LSB +: TAG_W];
        cfg_d[sel].en      = wdata[EN_BIT];
      end else begin
        cfg_d[sel].base_hi  = wdata[ADDR_W-1 -: HI_W];
        cfg_d[sel].base_ext = wdata[EXT_W-1:0];
      end
    end
  end

  // state, clock enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) cfg_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CS; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (is_size) begin
      rdata[ADDR_W-1 -: HI_W]   = cfg_q[sel].size_m1;
      rdata[TAG_LSB +: TAG_W]   = cfg_q[sel].tag;
      rdata[EN_BIT]             = cfg_q[sel].en;
    end else begin
      rdata[ADDR_W-1 -: HI_W]   = cfg_q[sel].base_hi;
      rdata[EXT_W-1:0]          = cfg_q[sel].base_ext;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) cfg_o[i] = cfg_q[i];
  end
endmodule

// File: rtl/dcs_win_match.sv
module dcs_win_match
  import dcs_pkg::*;
(
  input  logic [HI_W-1:0]   base_hi,
  input  logic [EXT_W-1:0]  base_ext,
  input  logic [HI_W-1:0]   size_m1,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              usable,
  output logic              hit
);
  logic [ADDR_W:0] lo_bound;
  logic [ADDR_W:0] span;
  logic [ADDR_W:0] hi_bound;
  logic [ADDR_W:0] addr_x;

  assign usable   = en && (base_ext == '0);
  assign lo_bound = {1'b0, base_hi, {GRAN_W{1'b0}}};
  assign span     = {1'b0, size_m1, {GRAN_W{1'b1}}} + 1'b1;
  assign hi_bound = lo_bound + span;
  assign addr_x   = {1'b0, addr};
  assign hit      = usable && (addr_x >= lo_bound) && (addr_x < hi_bound);
endmodule

// File: rtl/dcs_compact.sv
module dcs_compact #(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CNT_W = $clog2(NUM_CS + 1)
) (
  input  logic [NUM_CS-1:0]      usable,
  output logic [NUM_CS*CS_W-1:0] idx_flat,
  output logic [NUM_CS-1:0]      vld,
  output logic [CNT_W-1:0]       cnt
);
  logic [CS_W-1:0]  slot [NUM_CS];
  logic [CNT_W-1:0] n;

  always_comb begin
    n   = '0;
    vld = '0;
    for (int k = 0; k < NUM_CS; k++) slot[k] = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (usable[i]) begin
        slot[n[CS_W-1:0]] = CS_W'(i);
        vld[n[CS_W-1:0]]  = 1'b1;
        n = n + 1'b1;
      end
    end
    cnt = n;
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_flat
    assign idx_flat[k*CS_W +: CS_W] = slot[k];
  end
endmodule

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder
  import dcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int WA_W  = CS_W + 1,
  localparam int CNT_W = $clog2(NUM_CS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [WA_W-1:0]        reg_addr,
  input  logic [ADDR_W-1:0]      reg_wdata,
  output logic [ADDR_W-1:0]      reg_rdata,
  input  logic [ADDR_W-1:0]      lk_addr,
  output logic                   lk_hit,
  output logic [CS_W-1:0]        lk_cs,
  output logic [NUM_CS-1:0]      lk_attr,
  output logic [CNT_W-1:0]       use_cnt,
  output logic [NUM_CS*CS_W-1:0] use_idx,
  output logic [NUM_CS-1:0]      use_vld
);
  logic        rst_n_sync;
  win_cfg_t    cfg [NUM_CS];
  logic [NUM_CS-1:0] usable;
  logic [NUM_CS-1:0] hit;

  dcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dcs_regfile #(.NUM_CS(NUM_CS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (reg_wr_en),
    .reg_addr (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .cfg_o    (cfg)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    dcs_win_match u_match (
      .base_hi  (cfg[i].base_hi),
      .base_ext (cfg[i].base_ext),
      .size_m1  (cfg[i].size_m1),
      .en       (cfg[i].en),
      .addr     (lk_addr),
      .usable   (usable[i]),
      .hit      (hit[i])
    );
  end

  // lowest index wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_cs   = '0;
    lk_attr = '1;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit[i] && !lk_hit) begin
        lk_hit     = 1'b1;
        lk_cs      = CS_W'(i);
        lk_attr[i] = 1'b0;
      end
    end
  end

  dcs_compact #(.NUM_CS(NUM_CS)) u_compact (
    .usable   (usable),
    .idx_flat (use_idx),
    .vld      (use_vld),
    .cnt      (use_cnt)
  );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CNT_W = $clog2(NUM_CS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              lk_hit,
  input logic [CS_W-1:0]   lk_cs,
  input logic [NUM_CS-1:0] lk_attr,
  input logic [CNT_W-1:0]  use_cnt,
  input logic [NUM_CS-1:0] use_vld
);
  AST_HIT_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(lk_attr) == NUM_CS - 1)); // R7
  AST_HIT_ZERO_AT_CS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_attr[lk_cs]); // R7
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> ((&lk_attr) && (lk_cs == '0))); // R8
  AST_CNT_EQ_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(use_vld) == int'(use_cnt)); // R9
  AST_VLD_PACKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((use_vld + NUM_CS'(1)) & use_vld) == '0); // R9
  AST_HIT_NEEDS_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (use_cnt != '0)); // R5
  AST_IDLE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(use_cnt)); // R2
endmodule

bind dram_cs_decoder dcs_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .lk_hit    (lk_hit),
  .lk_cs     (lk_cs),
  .lk_attr   (lk_attr),
  .use_cnt   (use_cnt),
  .use_vld   (use_vld)
);

// File: tb/dram_cs_decoder_tb_top.sv
module dram_cs_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {addr, hit, cs, attr}
  localparam logic [38:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 2'd0, 4'hE},
    {32'h0FFF_FFFF, 1'b1, 2'd0, 4'hE},
    {32'h1000_0000, 1'b1, 2'd1, 4'hD},
    {32'h1FFF_FFFF, 1'b1, 2'd1, 4'hD},
    {32'h2000_0000, 1'b0, 2'd0, 4'hF},
    {32'h2FFF_FFFF, 1'b0, 2'd0, 4'hF},
    {32'hEFFF_FFFF, 1'b0, 2'd0, 4'hF},
    {32'hF000_0000, 1'b1, 2'd3, 4'h7},
    {32'hFFFF_FFFF, 1'b1, 2'd3, 4'h7},
    {32'h8000_0000, 1'b0, 2'd0, 4'hF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [1:0]  lk_cs;
  logic [3:0]  lk_attr;
  logic [2:0]  use_cnt;
  logic [7:0]  use_idx;
  logic [3:0]  use_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_attr(lk_attr), .use_cnt(use_cnt),
    .use_idx(use_idx), .use_vld(use_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic h,
                      input logic [1:0] c, input logic [3:0] at);
    lk_addr = a;
    #1;
    chk({req, " hit"},  32'(lk_hit),  32'(h));
    chk({req, " cs"},   32'(lk_cs),   32'(c));
    chk({req, " attr"}, 32'(lk_attr), 32'(at));
  endtask

  task automatic list(input string req, input logic [2:0] c, input logic [7:0] ix,
                      input logic [3:0] v);
    #1;
    chk({req, " cnt"}, 32'(use_cnt), 32'(c));
    chk({req, " idx"}, 32'(use_idx), 32'(ix));
    chk({req, " vld"}, 32'(use_vld), 32'(v));
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    list("R1", 3'd0, 8'h00, 4'h0);
    look("R1", 32'h0000_0000, 1'b0, 2'd0, 4'hF);
    for (int a = 0; a < 8; a++) rd("R1 rdata", 3'(a), 32'h0);

    // program: cs0 0x00..0x0F, cs1 0x10..0x1F, cs2 ext set, cs3 0xF0..0xFF
    wr(3'd0, 32'h0000_0000); wr(3'd1, 32'h0F00_0001);
    wr(3'd2, 32'h1000_0000); wr(3'd3, 32'h0F00_0001);
    wr(3'd4, 32'h2000_0001); wr(3'd5, 32'h0F00_0001);
    wr(3'd6, 32'hF000_0000); wr(3'd7, 32'h0F00_0001);
    list("R9 R5 ext excluded", 3'd3, 8'h34, 4'h7);

    // R4 R5 R7 R8 vector walk
    for (int i = 0; i < NV; i++)
      look("R4 R7 R8 vec", VEC[i][38:7], VEC[i][6], VEC[i][5:4], VEC[i][3:0]);

    // R2 R10: write visible only after the edge
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h2000_0000;
    look("R2 before edge", 32'h2000_0000, 1'b0, 2'd0, 4'hF);
    @(negedge clk);
    reg_wr_en = 1'b0;
    look("R2 R10 after edge", 32'h2000_0000, 1'b1, 2'd2, 4'hB);
    list("R9 all usable", 3'd4, 8'hE4, 4'hF);

    // R6 overlap
    wr(3'd3, 32'h3F00_0001); // cs1 0x10..0x4F covers cs2
    look("R6 cs1 over cs2", 32'h2500_0000, 1'b1, 2'd1, 4'hD);
    wr(3'd1, 32'h1F00_0001); // cs0 0x00..0x1F covers part of cs1
    look("R6 cs0 over cs1", 32'h1500_0000, 1'b1, 2'd0, 4'hE);

    // R5 disabled window
    wr(3'd1, 32'h1F00_0000);
    look("R5 disabled cs0", 32'h1500_0000, 1'b1, 2'd1, 4'hD);
    list("R9 R5 gap at cs0", 3'd3, 8'h39, 4'h7);

    // R3 field storage
    wr(3'd1, 32'hFFFF_FFFE);
    rd("R3 size fields", 3'd1, 32'hFF00_001C);
    wr(3'd0, 32'hABCD_EF3F);
    rd("R3 base fields", 3'd0, 32'hAB00_000F);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    list("R1 async", 3'd0, 8'h00, 4'h0);
    rd("R1 async rdata", 3'd3, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule